// File: doc/BRIEF.md
# Dual-Engine Counter Synchronizer

This block keeps two free-running event counters, one owned by a constant-loading engine and one owned by a draw engine, and uses them to pace the two engines against each other. Each engine bumps its own counter as it finishes units of work. Both counters can be loaded with a common starting value in a single command.

Each engine can also post a wait. The draw engine waits for its own counter to reach an absolute target. The constant engine waits while it is too far ahead, meaning the constant count minus the draw count is at or above a limit it supplies. While a wait is unresolved, that engine's stall output is high. Every wait is tracked in a register and re-checked each cycle until it resolves.

Top module: `ce_de_sync`

## Requirements
- R1: After reset both counters read zero and both stall outputs are low.
- R2: A load request (`load_req`) writes `{load_hi, load_lo}` into both counters; the new value shows on `ce_count` and `de_count` in the cycle after the request.
- R3: `ce_inc` adds one to the constant counter and `de_inc` adds one to the draw counter, visible the next cycle; a counter at all ones wraps to zero.
- R4: A load request issued in the same cycle as either increment wins, and both counters take the loaded value.
- R5: A draw wait (`de_wait_req` with target `{de_tgt_hi, de_tgt_lo}`) raises `de_stall` from the next cycle until the draw counter is unsigned greater than or equal to the target; `de_stall` is low in the same cycle that `de_count` first shows a satisfying value, and a wait that is already satisfied never raises it.
- R6: A constant wait (`ce_wait_req` with limit `ce_gap_max`) raises `ce_stall` while `ce_count - de_count` is unsigned greater than or equal to the zero-extended limit, and clears it once the difference falls below the limit.
- R7: The difference for R6 is a full-width modular subtraction, so a draw counter ahead of the constant counter gives a very large difference and keeps the constant engine stalled.
- R8: An increment or load issued in the same cycle as a wait request is applied before that wait is first evaluated.
- R9: A new wait request from an engine replaces that engine's pending wait.
- R10: With no load and no increment, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Load both counters |
| load_lo | input | DW | Low word of load value |
| load_hi | input | DW | High word of load value |
| ce_inc | input | 1 | Increment constant counter |
| de_inc | input | 1 | Increment draw counter |
| de_wait_req | input | 1 | Post a draw-engine wait |
| de_tgt_lo | input | DW | Low word of draw wait target |
| de_tgt_hi | input | DW | High word of draw wait target |
| ce_wait_req | input | 1 | Post a constant-engine wait |
| ce_gap_max | input | DW | Allowed lead of constant over draw counter |
| ce_count | output | 2*DW | Constant counter |
| de_count | output | 2*DW | Draw counter |
| ce_stall | output | 1 | Constant engine must wait |
| de_stall | output | 1 | Draw engine must wait |

## Verification
The bench builds the block with its default word width of 32, which gives 64-bit counters and the full-width modular difference. Random increments alone cannot reach the upper word or the wrap, so loads of values near the 32-bit boundary and near all ones bring carries into the high word, counter wrap, and negative differences (R7) within a few cycles. Wait targets and limits are drawn close to the current counts, so stalls both resolve and persist.

// File: rtl/ce_de_sync.sv
module ce_de_sync #(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [DW-1:0]    load_lo,
  input  logic [DW-1:0]    load_hi,
  input  logic             ce_inc,
  input  logic             de_inc,
  input  logic             de_wait_req,
  input  logic [DW-1:0]    de_tgt_lo,
  input  logic [DW-1:0]    de_tgt_hi,
  input  logic             ce_wait_req,
  input  logic [DW-1:0]    ce_gap_max,
  output logic [2*DW-1:0]  ce_count,
  output logic [2*DW-1:0]  de_count,
  output logic             ce_stall,
  output logic             de_stall
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] ce_q, de_q, ce_d, de_d, de_tgt_q;
  logic [DW-1:0] ce_lim_q;
  logic          ce_pend_q, de_pend_q;

  // R4: load wins over increments
  always_comb begin
    ce_d = load_req ? {load_hi, load_lo} : (ce_inc ? ce_q + 1'b1 : ce_q);
    de_d = load_req ? {load_hi, load_lo} : (de_inc ? de_q + 1'b1 : de_q);
  end

  // R8: waits are evaluated against the already-updated counters
  wire [CW-1:0] de_tgt   = de_wait_req ? {de_tgt_hi, de_tgt_lo} : de_tgt_q;
  wire [DW-1:0] ce_lim   = ce_wait_req ? ce_gap_max : ce_lim_q;
  wire [CW-1:0] gap_d    = ce_d - de_d;
  wire          de_short = de_d < de_tgt;
  wire          ce_ahead = gap_d >= {{DW{1'b0}}, ce_lim};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q      <= '0;
      de_q      <= '0;
      de_tgt_q  <= '0;
      ce_lim_q  <= '0;
      ce_pend_q <= 1'b0;
      de_pend_q <= 1'b0;
    end else begin
      ce_q      <= ce_d;
      de_q      <= de_d;
      de_tgt_q  <= de_tgt;
      ce_lim_q  <= ce_lim;
      de_pend_q <= (de_wait_req || de_pend_q) && de_short;
      ce_pend_q <= (ce_wait_req || ce_pend_q) && ce_ahead;
    end
  end

  assign ce_count = ce_q;
  assign de_count = de_q;
  assign ce_stall = ce_pend_q;
  assign de_stall = de_pend_q;

  a_r2_load_both: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (ce_q == {$past(load_hi), $past(load_lo)}) && (de_q == ce_q));

  a_r3_ce_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && ce_inc) |=> ce_q == $past(ce_q) + 1'b1);

  a_r3_de_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && de_inc) |=> de_q == $past(de_q) + 1'b1);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && !ce_inc && !de_inc) |=> $stable(ce_q) && $stable(de_q));

  a_r5_de_stall_short: assert property (@(posedge clk) disable iff (!rst_n)
    de_stall |-> de_q < de_tgt_q);

  a_r6_ce_stall_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    ce_stall |-> (ce_q - de_q) >= {{DW{1'b0}}, ce_lim_q});

  a_r5_no_spurious_de: assert property (@(posedge clk) disable iff (!rst_n)
    (!de_wait_req && !de_stall) |=> !de_stall);

  a_r6_no_spurious_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_wait_req && !ce_stall) |=> !ce_stall);
endmodule

// File: tb/ce_de_sync_tb.sv
module ce_de_sync_tb;
  localparam int DW = 32;
  localparam int CW = 2 * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_req = 0, ce_inc = 0, de_inc = 0, de_wait_req = 0, ce_wait_req = 0;
  logic [DW-1:0] load_lo = 0, load_hi = 0, de_tgt_lo = 0, de_tgt_hi = 0, ce_gap_max = 0;
  logic [CW-1:0] ce_count, de_count;
  logic ce_stall, de_stall;

  int tests = 0, fails = 0, cycles = 0;
  logic [CW-1:0] m_ce = 0, m_de = 0, m_tgt = 0;
  logic [DW-1:0] m_lim = 0;
  logic m_cp = 0, m_dp = 0;

  always #10 clk = ~clk;

  ce_de_sync #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_lo(load_lo), .load_hi(load_hi),
    .ce_inc(ce_inc), .de_inc(de_inc), .de_wait_req(de_wait_req), .de_tgt_lo(de_tgt_lo),
    .de_tgt_hi(de_tgt_hi), .ce_wait_req(ce_wait_req), .ce_gap_max(ce_gap_max),
    .ce_count(ce_count), .de_count(de_count), .ce_stall(ce_stall), .de_stall(de_stall));

  function automatic logic de_met(logic [CW-1:0] d, logic [CW-1:0] t);
    return d >= t;
  endfunction

  function automatic logic ce_ok(logic [CW-1:0] c, logic [CW-1:0] d, logic [DW-1:0] l);
    logic [CW-1:0] g;
    g = c - d;
    return g < {{DW{1'b0}}, l};
  endfunction

  task automatic chk(string tag, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    load_req = 0; ce_inc = 0; de_inc = 0; de_wait_req = 0; ce_wait_req = 0;
  endtask

  task automatic tick(string tag);
    logic [CW-1:0] nce, nde;
    nce = load_req ? {load_hi, load_lo} : (ce_inc ? m_ce + 1 : m_ce);
    nde = load_req ? {load_hi, load_lo} : (de_inc ? m_de + 1 : m_de);
    if (de_wait_req) m_tgt = {de_tgt_hi, de_tgt_lo};
    if (ce_wait_req) m_lim = ce_gap_max;
    m_dp = (de_wait_req || m_dp) && !de_met(nde, m_tgt);
    m_cp = (ce_wait_req || m_cp) && !ce_ok(nce, nde, m_lim);
    m_ce = nce;
    m_de = nde;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "ce_count", ce_count, m_ce);
    chk(tag, "de_count", de_count, m_de);
    chk(tag, "de_stall", {{(CW-1){1'b0}}, de_stall}, {{(CW-1){1'b0}}, m_dp});
    chk(tag, "ce_stall", {{(CW-1){1'b0}}, ce_stall}, {{(CW-1){1'b0}}, m_cp});
    idle();
  endtask

  task automatic load(logic [CW-1:0] v, string tag);
    load_req = 1; {load_hi, load_lo} = v;
    tick(tag);
  endtask

  task automatic de_wait(logic [CW-1:0] t);
    de_wait_req = 1; {de_tgt_hi, de_tgt_lo} = t;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ce_count", ce_count, '0);
    chk("R1", "de_count", de_count, '0);
    chk("R1", "stalls", {62'b0, ce_stall, de_stall}, '0);

    // R10 hold with no requests
    tick("R10"); tick("R10");

    // R2 load and R3 wrap
    load(64'h0000_0001_FFFF_FFFE, "R2");
    ce_inc = 1; de_inc = 1; tick("R3");
    ce_inc = 1; tick("R3");
    load('1, "R2");
    ce_inc = 1; tick("R3");
    chk("R3", "wrap", ce_count, '0);

    // R4 load beats increments
    load_req = 1; {load_hi, load_lo} = 64'h1234_5678_9ABC_DEF0; ce_inc = 1; de_inc = 1;
    tick("R4");
    chk("R4", "equal", ce_count, de_count);

    // R5 draw wait: stall then release on reaching target
    load(64'd100, "R2");
    de_wait(64'd102); tick("R5");
    chk("R5", "stalled", {63'b0, de_stall}, 64'd1);
    de_inc = 1; tick("R5");
    de_inc = 1; tick("R5");
    chk("R5", "released", {63'b0, de_stall}, 64'd0);
    de_wait(64'd50); tick("R5");
    chk("R5", "satisfied", {63'b0, de_stall}, 64'd0);

    // R8 increment in the wait cycle counts
    de_wait(m_de + 1); de_inc = 1; tick("R8");
    chk("R8", "no stall", {63'b0, de_stall}, 64'd0);

    // R9 replacement
    de_wait(m_de + 5); tick("R9");
    de_wait(m_de); tick("R9");
    chk("R9", "replaced", {63'b0, de_stall}, 64'd0);

    // R6 constant wait
    load(64'd10, "R2");
    ce_inc = 1; tick("R6"); ce_inc = 1; tick("R6");
    ce_wait_req = 1; ce_gap_max = 2; tick("R6");
    chk("R6", "ahead", {63'b0, ce_stall}, 64'd1);
    de_inc = 1; tick("R6");
    chk("R6", "released", {63'b0, ce_stall}, 64'd0);

    // R7 draw ahead -> modular gap huge
    load(64'd0, "R2");
    de_inc = 1; tick("R7");
    ce_wait_req = 1; ce_gap_max = '1; tick("R7");
    chk("R7", "wrapped gap", {63'b0, ce_stall}, 64'd1);
    ce_inc = 1; tick("R7");
    chk("R7", "equal counts", {63'b0, ce_stall}, 64'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 3) begin
        load_req = 1;
        {load_hi, load_lo} = ($urandom % 2) ? {32'h0, 32'hFFFF_FFF0 + ($urandom % 16)}
                                            : {~32'h0, 32'hFFFF_FFF0 + ($urandom % 16)};
      end
      ce_inc = ($urandom % 3) == 0;
      de_inc = ($urandom % 3) == 0;
      if (($urandom % 10) == 0) de_wait(m_de + ($urandom % 8));
      if (($urandom % 10) == 0) begin
        ce_wait_req = 1; ce_gap_max = $urandom % 6;
      end
      tick("R2/R3/R5/R6");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule